// File: doc/BRIEF.md
# Parallel Bus Phase Sequencer (Initiator Side)

This block is the initiator-side controller for a shared 8-bit parallel peripheral bus. Up to eight devices share the bus, and each one has a unique 3-bit ID. The sequencer watches the busy and select lines and waits until the bus has been idle for a fixed number of clocks. It then contends for ownership by placing its own ID bit on the data lines. The contender with the highest ID takes the bus.

The winner selects a target by putting both IDs on the data lines and raising select. After that it simply follows the phase lines driven by the target. The phase lines report one of four kinds of transfer: command, data, status or message. The sequencer answers every byte request with an acknowledge. The transaction ends when the bus goes free again.

A target that earlier released the bus can reconnect with a reselection. The sequencer answers it by asserting busy. A bus-reset input returns the sequencer to the free state from any phase within one clock.

Top module: `pbus_phase_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `phase_o` is 0 (free) and `busy_o`, `select_o`, `data_oe_o` and `xfer_ack_o` are all low.
- R2: A pending request enters arbitration (`phase_o` = 1) only on the clock edge after the bus has been seen idle (busy and select both low) on FREE_MIN consecutive edges. While the bus stays busy the sequencer stays in free.
- R3: During arbitration the block drives `busy_o` high and drives `data_o` with only bit `my_id_i` set, with `data_oe_o` high.
- R4: The data lines are judged on the ARB_DLY-th edge in arbitration. If any bit above `my_id_i` is set, the block returns to free with busy and data released and `lost_o` high for one cycle. The request stays pending and is retried once the bus is idle again.
- R5: If no higher bit is set (lower bits do not matter), the block enters selection (`phase_o` = 2). It raises `select_o`, releases `busy_o`, and drives `data_o` with bits `my_id_i` and `tgt_id_i` set.
- R6: If busy is not seen within SEL_TMO edges of selection, the block returns to free, drops the request and pulses `sel_fail_o`.
- R7: Busy seen during selection moves the block to the information phases and releases `select_o`.
- R8: In the information phases `phase_o` follows the target's phase lines. `ph_note_i`=1 gives 7 (message). Otherwise `ph_ctrl_i`=1 gives 4 (command) when `ph_dir_i`=0 or 6 (status) when `ph_dir_i`=1. `ph_ctrl_i`=0 gives 5 (data).
- R9: `xfer_ack_o` rises on the edge after `xfer_req_i` is seen high and falls on the edge after `xfer_req_i` is seen low. When `ph_dir_i`=1 (inbound) the byte on the data lines is captured into `rx_byte_o`, and `rx_valid_o` is high for one cycle, on the same edge that raises the acknowledge.
- R10: When `ph_dir_i`=0 (outbound), `tx_byte_i` is latched at the request. It is driven on `data_o` with `data_oe_o` high for as long as the acknowledge is high.
- R11: In free, with busy low and select high, the block detects a reselection when exactly two data bits are set and one of them is `my_id_i`. It then enters reselection (`phase_o` = 3), drives `busy_o`, and reports the other ID on `resel_id_o`. When select falls with busy held by the target, it enters the information phases and releases busy. A select without the own bit is ignored.
- R12: `bus_rst_i` high on an edge puts the block in free after that edge, from any phase. All driven lines and the acknowledge are low, and any pending request is dropped.
- R13: In the information phases, busy and select both low move the block to free, and `done_o` is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst_i | input | 1 | Bus reset seen on the shared bus |
| my_id_i | input | 3 | Own device ID (static) |
| start_i | input | 1 | Request a transaction (one-cycle pulse) |
| tgt_id_i | input | 3 | Target ID, sampled with `start_i` |
| tx_byte_i | input | 8 | Byte to send in an outbound phase |
| busy_in_i | input | 1 | Busy line as seen on the bus (wired-OR) |
| select_in_i | input | 1 | Select line as seen on the bus (wired-OR) |
| data_in_i | input | 8 | Data lines as seen on the bus (wired-OR) |
| ph_ctrl_i | input | 1 | Target phase line: control vs data |
| ph_dir_i | input | 1 | Target phase line: 1 = toward initiator |
| ph_note_i | input | 1 | Target phase line: message |
| xfer_req_i | input | 1 | Target byte request |
| busy_o | output | 1 | Own busy drive |
| select_o | output | 1 | Own select drive |
| data_o | output | 8 | Own data-line drive |
| data_oe_o | output | 1 | Data-line drive enable |
| xfer_ack_o | output | 1 | Byte acknowledge |
| phase_o | output | 3 | Current phase code (see R2, R5, R8, R11) |
| lost_o | output | 1 | Arbitration lost pulse |
| sel_fail_o | output | 1 | Selection timeout pulse |
| done_o | output | 1 | Bus returned free pulse |
| resel_id_o | output | 3 | ID of the reselecting target |
| rx_valid_o | output | 1 | Inbound byte captured pulse |
| rx_byte_o | output | 8 | Last inbound byte |

## Verification
The hardest case to reach from the ports is a loss of arbitration. The losing ID has to be on the bus while the block is in arbitration, before the judgement edge ARB_DLY clocks in. It must then be withdrawn in time for the retried request to get its own idle window. The bench watches `phase_o`, and as soon as arbitration shows it places a contender's busy and ID bit on the wired-OR model of the bus. It keeps them there through the judgement and withdraws them afterwards, then repeats with a lower contender to show the retry winning. Reselection and bus reset in the middle of a handshake are reached the same way, by reacting to the phase code, not by fixed delays.

// File: rtl/pbus_seq_pkg.sv
// Shared types for the parallel bus phase sequencer.
// Assumes: a phase code of 3 bits that is visible at the top-level port.
package pbus_seq_pkg;

    // Externally visible phase code
    typedef enum logic [2:0] {
        PH_FREE  = 3'd0,
        PH_ARB   = 3'd1,
        PH_SEL   = 3'd2,
        PH_RESEL = 3'd3,
        PH_CMD   = 3'd4,
        PH_DATA  = 3'd5,
        PH_STAT  = 3'd6,
        PH_MSG   = 3'd7
    } phase_e;

    // Internal sequencer state
    typedef enum logic [2:0] {
        ST_FREE,
        ST_ARB,
        ST_SEL,
        ST_RESEL,
        ST_INFO
    } seq_st_e;

    // Map the target's three phase lines onto an information phase code
    function automatic phase_e info_phase(input logic ctrl, input logic dir, input logic note);
        if (note)      return PH_MSG;
        else if (ctrl) return dir ? PH_STAT : PH_CMD;
        else           return PH_DATA;
    endfunction

endpackage

// File: rtl/pbus_free_timer.sv
// Bus-idle qualifier: counts consecutive idle clocks, saturating at FREE_MIN.
// Assumes: idle_i is already gated with bus reset by the parent.
module pbus_free_timer #(
    parameter int FREE_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    output logic free_o
);
    localparam int CW = $clog2(FREE_MIN + 1);

    logic [CW-1:0] cnt_q;

    // Count idle edges, clear on any activity
    always_ff @(posedge clk) begin
        if (!rst_n || !idle_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(FREE_MIN)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign free_o = (cnt_q == CW'(FREE_MIN));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(FREE_MIN));
    p_free_needs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        free_o |-> $past(idle_i));

endmodule

// File: rtl/pbus_contend.sv
// Data-line decoder for arbitration and reselection.
// Judges whether a higher ID is present, and recognises a reselection pattern
// (own bit plus exactly one other). Purely combinational.
module pbus_contend #(
    parameter int DATA_W = 8,
    parameter int ID_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [ID_W-1:0]   my_id_i,
    output logic              higher_o,
    output logic              resel_hit_o,
    output logic [ID_W-1:0]   resel_id_o
);
    logic [DATA_W-1:0] above_mask;
    logic [DATA_W-1:0] others;

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_mask
            assign above_mask[g] = (ID_W'(g) > my_id_i);
            assign others[g]     = data_i[g] && (ID_W'(g) != my_id_i);
        end
    endgenerate

    assign higher_o    = |(data_i & above_mask);
    assign resel_hit_o = data_i[my_id_i] && ($countones(data_i) == 2);

    // Pick the one other ID present on the lines
    always_comb begin
        resel_id_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (others[i]) resel_id_o = ID_W'(i);
        end
    end

endmodule

// File: rtl/pbus_handshake.sv
// Per-byte request/acknowledge responder for the information phases.
// Assumes: en_i is low outside the information phases; the direction is
// taken from the phase line at the moment the request is first seen.
module pbus_handshake #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              req_i,
    input  logic              dir_i,
    input  logic [DATA_W-1:0] tx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ack_o,
    output logic              drive_o,
    output logic [DATA_W-1:0] tx_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_byte_o
);
    logic ack_q;
    logic dir_q;
    logic [DATA_W-1:0] tx_q;
    logic rx_valid_q;
    logic [DATA_W-1:0] rx_q;

    // Acknowledge sequencing and byte capture
    always_ff @(posedge clk) begin
        rx_valid_q <= 1'b0;
        if (!rst_n || !en_i) begin
            ack_q <= 1'b0;
            dir_q <= 1'b0;
            tx_q  <= '0;
        end else if (!ack_q && req_i) begin
            ack_q <= 1'b1;
            dir_q <= dir_i;
            if (dir_i) begin
                rx_valid_q <= 1'b1;
                rx_q       <= data_i;
            end else begin
                tx_q <= tx_i;
            end
        end else if (ack_q && !req_i) begin
            ack_q <= 1'b0;
        end
        if (!rst_n) rx_q <= '0;
    end

    assign ack_o      = ack_q;
    assign drive_o    = ack_q && !dir_q;
    assign tx_o       = tx_q;
    assign rx_valid_o = rx_valid_q;
    assign rx_byte_o  = rx_q;

    p_ack_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_i));
    p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !req_i) |=> !ack_o);
    p_drive_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> ack_o);

endmodule

// File: rtl/pbus_phase_seq.sv
// Initiator-side phase sequencer for a shared 8-bit parallel bus.
// Waits for a qualified idle bus, contends by ID (highest wins), selects a
// target, then follows target-driven phases until the bus is free again.
// Also answers reselection. Assumes all *_in_i lines are the wired-OR of every
// device including this one, and that my_id_i is static.
module pbus_phase_seq
    import pbus_seq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ID_W     = $clog2(DATA_W),
    parameter int FREE_MIN = 4,
    parameter int ARB_DLY  = 3,
    parameter int SEL_TMO  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_i,
    input  logic [ID_W-1:0]   my_id_i,
    input  logic              start_i,
    input  logic [ID_W-1:0]   tgt_id_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              busy_in_i,
    input  logic              select_in_i,
    input  logic [DATA_W-1:0] data_in_i,
    input  logic              ph_ctrl_i,
    input  logic              ph_dir_i,
    input  logic              ph_note_i,
    input  logic              xfer_req_i,
    output logic              busy_o,
    output logic              select_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              xfer_ack_o,
    output logic [2:0]        phase_o,
    output logic              lost_o,
    output logic              sel_fail_o,
    output logic              done_o,
    output logic [ID_W-1:0]   resel_id_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_byte_o
);
    localparam int ACW = $clog2(ARB_DLY + 1);
    localparam int SCW = $clog2(SEL_TMO + 1);

    seq_st_e          st_q;
    logic             pend_q;
    logic [ID_W-1:0]  tgt_q;
    logic [ACW-1:0]   arb_cnt_q;
    logic [SCW-1:0]   sel_cnt_q;
    logic             lost_q, fail_q, done_q;
    logic [ID_W-1:0]  resel_q;

    logic             free_ok;
    logic             higher_seen;
    logic             resel_hit;
    logic [ID_W-1:0]  resel_id;
    logic             hs_drive;
    logic [DATA_W-1:0] hs_tx;
    logic [DATA_W-1:0] own_bit;
    logic             in_arb;

    assign own_bit = DATA_W'(1) << my_id_i;
    assign in_arb  = (st_q == ST_ARB);

    pbus_free_timer #(.FREE_MIN(FREE_MIN)) u_free (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle_i (!busy_in_i && !select_in_i && !bus_rst_i),
        .free_o (free_ok)
    );

    pbus_contend #(.DATA_W(DATA_W), .ID_W(ID_W)) u_contend (
        .data_i      (data_in_i),
        .my_id_i     (my_id_i),
        .higher_o    (higher_seen),
        .resel_hit_o (resel_hit),
        .resel_id_o  (resel_id)
    );

    pbus_handshake #(.DATA_W(DATA_W)) u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       ((st_q == ST_INFO) && !bus_rst_i),
        .req_i      (xfer_req_i),
        .dir_i      (ph_dir_i),
        .tx_i       (tx_byte_i),
        .data_i     (data_in_i),
        .ack_o      (xfer_ack_o),
        .drive_o    (hs_drive),
        .tx_o       (hs_tx),
        .rx_valid_o (rx_valid_o),
        .rx_byte_o  (rx_byte_o)
    );

    // Phase sequencing, request latch and event pulses
    always_ff @(posedge clk) begin
        lost_q <= 1'b0;
        fail_q <= 1'b0;
        done_q <= 1'b0;
        if (!rst_n) begin
            st_q      <= ST_FREE;
            pend_q    <= 1'b0;
            tgt_q     <= '0;
            arb_cnt_q <= '0;
            sel_cnt_q <= '0;
            resel_q   <= '0;
        end else if (bus_rst_i) begin
            st_q   <= ST_FREE;
            pend_q <= 1'b0;
        end else begin
            if (start_i && !pend_q) begin
                pend_q <= 1'b1;
                tgt_q  <= tgt_id_i;
            end
            case (st_q)
                ST_FREE: begin
                    if (select_in_i && !busy_in_i && resel_hit) begin
                        st_q    <= ST_RESEL;
                        resel_q <= resel_id;
                    end else if (pend_q && free_ok) begin
                        st_q      <= ST_ARB;
                        arb_cnt_q <= '0;
                    end
                end
                ST_ARB: begin
                    if (arb_cnt_q == ACW'(ARB_DLY - 1)) begin
                        if (higher_seen) begin
                            st_q   <= ST_FREE;
                            lost_q <= 1'b1;
                        end else begin
                            st_q      <= ST_SEL;
                            sel_cnt_q <= '0;
                        end
                    end else begin
                        arb_cnt_q <= arb_cnt_q + 1'b1;
                    end
                end
                ST_SEL: begin
                    if (busy_in_i) begin
                        st_q   <= ST_INFO;
                        pend_q <= 1'b0;
                    end else if (sel_cnt_q == SCW'(SEL_TMO - 1)) begin
                        st_q   <= ST_FREE;
                        pend_q <= 1'b0;
                        fail_q <= 1'b1;
                    end else begin
                        sel_cnt_q <= sel_cnt_q + 1'b1;
                    end
                end
                ST_RESEL: begin
                    if (!select_in_i) st_q <= busy_in_i ? ST_INFO : ST_FREE;
                end
                ST_INFO: begin
                    if (!busy_in_i && !select_in_i) begin
                        st_q   <= ST_FREE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= ST_FREE;
            endcase
        end
    end

    // Bus drive decode from the current state
    always_comb begin
        busy_o    = (st_q == ST_ARB) || (st_q == ST_RESEL);
        select_o  = (st_q == ST_SEL);
        data_oe_o = 1'b0;
        data_o    = '0;
        case (st_q)
            ST_ARB:  begin data_oe_o = 1'b1; data_o = own_bit; end
            ST_SEL:  begin data_oe_o = 1'b1; data_o = own_bit | (DATA_W'(1) << tgt_q); end
            ST_INFO: begin data_oe_o = hs_drive; data_o = hs_drive ? hs_tx : '0; end
            default: ;
        endcase
    end

    // Phase code presented to the host side
    always_comb begin
        case (st_q)
            ST_ARB:   phase_o = PH_ARB;
            ST_SEL:   phase_o = PH_SEL;
            ST_RESEL: phase_o = PH_RESEL;
            ST_INFO:  phase_o = info_phase(ph_ctrl_i, ph_dir_i, ph_note_i);
            default:  phase_o = PH_FREE;
        endcase
    end

    assign lost_o     = lost_q;
    assign sel_fail_o = fail_q;
    assign done_o     = done_q;
    assign resel_id_o = resel_q;

    p_arb_after_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_arb) |-> $past(free_ok));
    p_loss_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |-> (!busy_o && !data_oe_o && !select_o));
    p_sel_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
        select_o |-> (data_oe_o && data_o[my_id_i] && $countones(data_o) <= 2 && !busy_o));
    p_info_no_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o >= 3'(PH_CMD)) |-> !select_o);
    p_bus_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_i |=> (phase_o == 3'(PH_FREE) && !busy_o && !select_o && !data_oe_o && !xfer_ack_o));

endmodule

// File: tb/pbus_phase_seq_tb.sv
// Scoreboard bench: a target/contender model drives the wired-OR bus, the
// inbound driver queues expected bytes, a monitor pops and compares them.
module pbus_phase_seq_tb_top;
    localparam int CLK_P    = 10;
    localparam int DW       = 8;
    localparam int SEL_TMO  = 16;
    localparam logic [2:0] MY = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst = 1'b0, start = 1'b0;
    logic [2:0] tgt = '0;
    logic [DW-1:0] tb_tx = '0, tb_data = '0;
    logic tb_busy = 1'b0, tb_sel = 1'b0, tb_ctrl = 1'b0, tb_dir = 1'b0, tb_note = 1'b0, tb_req = 1'b0;

    logic busy_o, select_o, data_oe_o, xfer_ack_o, lost_o, sel_fail_o, done_o, rx_valid_o;
    logic [DW-1:0] data_o, rx_byte_o;
    logic [2:0] phase_o, resel_id_o;

    logic          bus_busy, bus_sel;
    logic [DW-1:0] bus_data;
    assign bus_busy = tb_busy | busy_o;
    assign bus_sel  = tb_sel | select_o;
    assign bus_data = tb_data | (data_oe_o ? data_o : '0);

    int checks = 0, errors = 0;
    logic [DW-1:0] exp_q[$];
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    pbus_phase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst), .my_id_i(MY),
        .start_i(start), .tgt_id_i(tgt), .tx_byte_i(tb_tx),
        .busy_in_i(bus_busy), .select_in_i(bus_sel), .data_in_i(bus_data),
        .ph_ctrl_i(tb_ctrl), .ph_dir_i(tb_dir), .ph_note_i(tb_note), .xfer_req_i(tb_req),
        .busy_o(busy_o), .select_o(select_o), .data_o(data_o), .data_oe_o(data_oe_o),
        .xfer_ack_o(xfer_ack_o), .phase_o(phase_o), .lost_o(lost_o),
        .sel_fail_o(sel_fail_o), .done_o(done_o), .resel_id_o(resel_id_o),
        .rx_valid_o(rx_valid_o), .rx_byte_o(rx_byte_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input logic [2:0] p, input string req);
        int k = 0;
        while (phase_o !== p && k < 60) begin step(1); k++; end
        chk(req, phase_o, p);
    endtask

    // Driver: inbound byte from the target, expected value queued first
    task automatic send_in(input logic [DW-1:0] b);
        exp_q.push_back(b);
        tb_data = b; tb_req = 1'b1;
        step(1);
        chk("R9 ack high", xfer_ack_o, 1);
        tb_req = 1'b0; tb_data = '0;
        step(1);
        chk("R9 ack low", xfer_ack_o, 0);
    endtask

    // Monitor: pop and compare each captured inbound byte
    always @(negedge clk) begin
        if (rst_n && rx_valid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected byte: actual %0h expected none", rx_byte_o);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                if (rx_byte_o !== e) begin
                    errors++;
                    $display("FAIL R9 rx byte: actual %0h expected %0h", rx_byte_o, e);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R1 phase", phase_o, 0);
        chk("R1 drives", {busy_o, select_o, data_oe_o, xfer_ack_o}, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 after release", {phase_o, busy_o, select_o, data_oe_o}, 0);

        // R2: busy bus holds off arbitration
        tb_busy = 1'b1; tgt = 3'd2; start = 1'b1;
        step(1); start = 1'b0;
        step(10);
        chk("R2 held while busy", phase_o, 0);
        tb_busy = 1'b0;
        step(4);
        chk("R2 not before idle window", phase_o, 0);
        step(1);
        chk("R2 arbitration entered", phase_o, 1);
        chk("R3 busy and own bit", {busy_o, data_oe_o, data_o}, {2'b11, 8'h20});

        // R4: higher contender (ID 7) wins
        tb_busy = 1'b1; tb_data = 8'h80;
        step(2);
        chk("R4 still judging", phase_o, 1);
        step(1);
        chk("R4 lost to free", phase_o, 0);
        chk("R4 lost pulse, lines released", {lost_o, busy_o, data_oe_o}, 3'b100);
        tb_busy = 1'b0; tb_data = '0;

        // R4 retry, R5 win against a lower contender (ID 0)
        step(5);
        chk("R4 retry arbitration", phase_o, 1);
        tb_busy = 1'b1; tb_data = 8'h01;
        step(3);
        chk("R5 selection", phase_o, 2);
        chk("R5 select lines", {select_o, busy_o, data_oe_o, data_o}, {3'b101, 8'h24});
        tb_busy = 1'b0; tb_data = '0;
        step(2);
        chk("R5 waiting target", phase_o, 2);
        tb_busy = 1'b1; tb_ctrl = 1'b1; tb_dir = 1'b0;
        step(1);
        chk("R7 select released", select_o, 0);
        chk("R8 command phase", phase_o, 4);

        // R10: outbound command byte
        tb_tx = 8'hA5; tb_req = 1'b1;
        step(1);
        chk("R10 driven byte", {xfer_ack_o, data_oe_o, data_o}, {2'b11, 8'hA5});
        tb_req = 1'b0;
        step(1);
        chk("R10 released", {xfer_ack_o, data_oe_o}, 0);

        // R8/R9: inbound data, status, message
        tb_ctrl = 1'b0; tb_dir = 1'b1;
        step(1);
        chk("R8 data phase", phase_o, 5);
        send_in(8'h3C); send_in(8'h00); send_in(8'hFF);
        tb_ctrl = 1'b1;
        step(1);
        chk("R8 status phase", phase_o, 6);
        send_in(8'h02);
        tb_note = 1'b1;
        step(1);
        chk("R8 message phase", phase_o, 7);
        send_in(8'h00);
        chk("R9 all bytes seen", exp_q.size(), 0);

        // R13: target releases the bus
        tb_busy = 1'b0; tb_ctrl = 1'b0; tb_dir = 1'b0; tb_note = 1'b0;
        step(1);
        chk("R13 back to free", {phase_o, done_o}, {3'd0, 1'b1});
        step(1);
        chk("R13 done one cycle", done_o, 0);

        // R6: selection with no response
        tgt = 3'd3; start = 1'b1;
        step(1); start = 1'b0;
        wait_phase(3'd2, "R6 reach selection");
        step(SEL_TMO - 1);
        chk("R6 still selecting", phase_o, 2);
        step(1);
        chk("R6 timeout", {phase_o, sel_fail_o, select_o}, {3'd0, 1'b1, 1'b0});
        step(20);
        chk("R6 request dropped", phase_o, 0);

        // R11: select for others ignored, then reselection of this device
        tb_sel = 1'b1; tb_data = 8'h41;
        step(2);
        chk("R11 foreign select ignored", {phase_o, busy_o}, 0);
        tb_data = 8'h60;
        step(1);
        chk("R11 reselected", {phase_o, busy_o, resel_id_o}, {3'd3, 1'b1, 3'd6});
        tb_busy = 1'b1; tb_sel = 1'b0; tb_data = '0;
        step(1);
        chk("R11 into info", {phase_o, busy_o}, {3'd5, 1'b0});

        // R12: bus reset in the middle of a handshake
        tb_dir = 1'b1; tb_req = 1'b1; exp_q.push_back(8'h00);
        step(1);
        chk("R12 ack before reset", xfer_ack_o, 1);
        bus_rst = 1'b1;
        step(1);
        chk("R12 reset from info", {phase_o, xfer_ack_o, busy_o, data_oe_o}, 0);
        bus_rst = 1'b0; tb_req = 1'b0; tb_busy = 1'b0; tb_dir = 1'b0;

        // R12: bus reset during arbitration
        tgt = 3'd1; start = 1'b1;
        step(1); start = 1'b0;
        wait_phase(3'd1, "R12 reach arbitration");
        bus_rst = 1'b1;
        step(1);
        chk("R12 reset from arbitration", {phase_o, busy_o, data_oe_o}, 0);
        bus_rst = 1'b0;
        step(20);
        chk("R12 request dropped", phase_o, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule